// File: doc/BRIEF.md
# Transport Packet Buffer Writer

This block takes a byte stream of 188-byte transport packets that an upstream filter has already selected and stores them in system memory. Bytes are packed little-endian into 32-bit words and sent out on a simple word write port. The words fill a linear buffer that holds a fixed number of packets, eight by default, and starts at a base address that software programs. The block counts the packets it has completed. It raises a transfer-done status once that count reaches a programmable threshold. If a new packet starts while the buffer is already full, the block discards the packet and raises an overflow status.

Software works through two registers. A base register holds the buffer start address. Writing it re-arms the buffer, so filling starts again at the first word. A combined control/status word carries:
- the packet count in its top byte
- the done and overflow status bits
- four interrupt mask bits
- a write-one acknowledge bit
- an active-low run bit that holds the stream logic in reset while it is clear
- the packet threshold

The interrupt line is high while an unmasked status bit is set.

Top module: `tsb_top`

## Requirements
- R1: Stream bytes are packed little-endian: byte 4k of the buffer goes in bits 7:0 of word k and byte 4k+3 in bits 31:24. Each word appears on the memory port one cycle after the byte that completes it is accepted, giving 47 words per packet.
- R2: Word k of the buffer is written at address base + 4k, and consecutive packets are contiguous. Select 0 reads back the base register.
- R3: Bits 31:24 of the control/status word (select 1) give the number of completed packets. The count updates one cycle after the last byte of a packet is accepted and never exceeds the buffer size (8).
- R4: Done (bit 16) is set in the cycle after a packet completes if the new count is greater than or equal to the threshold in bits 6:0.
- R5: A packet whose first byte arrives while the count equals the buffer size is discarded with no memory writes, and overflow (bit 11) is set. The count stays at the buffer size.
- R6: irq is high while done is set and its mask (bit 17) is clear, or while overflow is set and its mask (bit 14) is clear. Mask bits 13 and 12 are stored and read back but have no effect on irq.
- R7: Writing the control word with bit 8 set clears done and overflow in the next cycle. A new status event in the same cycle takes priority. Bit 8 always reads 0.
- R8: Writing the base register clears the packet count and the word pointer, so the next packet is written from the new base. Done and overflow are left unchanged.
- R9: While run (bit 15) is 0, the count, the word pointer, done and overflow are held at 0 and stream bytes are ignored. This takes effect in the cycle after the write that clears run. The mask bits and threshold keep their values, and setting run again restarts capture at the base address.
- R10: Stream bytes that arrive outside a packet (no start flag since the last packet ended) are ignored.
- R11: After reset the control/status word reads 0x00027004 (all four masks set, run 0, threshold 4), the base reads 0, and irq and mem_we are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| s_valid | input | 1 | Stream byte valid |
| s_sop | input | 1 | Byte is the first of a packet |
| s_data | input | 8 | Stream byte |
| csr_wr | input | 1 | Register write strobe |
| csr_sel | input | 1 | Register select: 0 base, 1 control/status |
| csr_wdata | input | 32 | Register write data |
| csr_rdata | output | 32 | Read data of the selected register (combinational) |
| mem_we | output | 1 | Memory word write strobe |
| mem_addr | output | ADDR_W | Memory byte address of the word |
| mem_wdata | output | 32 | Memory word data |
| irq | output | 1 | Interrupt request |

## Verification
Every result lags its cause by one register stage. A memory word shows up in the cycle after its fourth byte. The count and done status change in the cycle after the last byte of a packet, and overflow in the cycle after a rejected first byte. Acknowledge, re-arm and run changes act in the cycle after the register write. The bench drives inputs on falling edges and samples on the next falling edge, which is half a cycle after the edge that registers each result. A falling-edge monitor matches every memory write against a queue of expected words built by the bench model as bytes are sent.

// File: rtl/tsb_pkg.sv
package tsb_pkg;
  localparam int PKT_BYTES     = 188;
  localparam int WORD_BYTES    = 4;
  localparam int WORDS_PER_PKT = PKT_BYTES / WORD_BYTES;
  localparam int LAST_BYTE     = PKT_BYTES - 1;
  localparam int IDX_W         = $clog2(PKT_BYTES + 1);
  localparam int THR_W         = 7;

  localparam int B_CNT_LO = 24;
  localparam int B_MDONE  = 17;
  localparam int B_DONE   = 16;
  localparam int B_RUN    = 15;
  localparam int B_MOVR   = 14;
  localparam int B_MAF    = 13;
  localparam int B_MLOCK  = 12;
  localparam int B_OVR    = 11;
  localparam int B_ACK    = 8;

  typedef struct packed {
    logic done;
    logic ovr;
    logic afull;
    logic lock;
  } mask_t;
endpackage

// File: rtl/tsb_rst_sync.sv
module tsb_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [1:0] sr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sr_q <= 2'b00;
    else        sr_q <= {sr_q[0], 1'b1};
  end

  assign rst_n_sync = sr_q[1];
endmodule

// File: rtl/tsb_csr.sv
module tsb_csr import tsb_pkg::*; #(
  parameter int ADDR_W    = 32,
  parameter int CNT_W     = 4,
  parameter int THR_RESET = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr,
  input  logic              sel,
  input  logic [31:0]       wdata,
  input  logic [CNT_W-1:0]  cnt,
  input  logic              done,
  input  logic              ovr,
  output logic [31:0]       rdata,
  output logic [ADDR_W-1:0] base,
  output logic [THR_W-1:0]  thr,
  output mask_t             mask,
  output logic              rearm,
  output logic              ack,
  output logic              kill
);
  logic [ADDR_W-1:0] base_q, base_n;
  logic [THR_W-1:0]  thr_q, thr_n;
  mask_t             mask_q, mask_n;
  logic              run_q, run_n;
  logic              wr_base, wr_ctrl;

  assign wr_base = wr & ~sel;
  assign wr_ctrl = wr & sel;

  always_comb begin
    base_n = base_q;
    thr_n  = thr_q;
    mask_n = mask_q;
    run_n  = run_q;
    if (wr_base) base_n = wdata[ADDR_W-1:0];
    if (wr_ctrl) begin
      thr_n      = wdata[THR_W-1:0];
      run_n      = wdata[B_RUN];
      mask_n.done  = wdata[B_MDONE];
      mask_n.ovr   = wdata[B_MOVR];
      mask_n.afull = wdata[B_MAF];
      mask_n.lock  = wdata[B_MLOCK];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q <= '0;
      thr_q  <= THR_W'(THR_RESET);
      mask_q <= '1;
      run_q  <= 1'b0;
    end else begin
      if (wr_base) base_q <= base_n;
      if (wr_ctrl) begin
        thr_q  <= thr_n;
        mask_q <= mask_n;
        run_q  <= run_n;
      end
    end
  end

  assign rearm = wr_base;
  assign ack   = wr_ctrl & wdata[B_ACK];
  assign kill  = ~run_q | (wr_ctrl & ~wdata[B_RUN]);
  assign base  = base_q;
  assign thr   = thr_q;
  assign mask  = mask_q;

  always_comb begin
    rdata = '0;
    if (!sel) begin
      rdata[ADDR_W-1:0] = base_q;
    end else begin
      rdata[31:B_CNT_LO] = 8'(cnt);
      rdata[B_MDONE]     = mask_q.done;
      rdata[B_DONE]      = done;
      rdata[B_RUN]       = run_q;
      rdata[B_MOVR]      = mask_q.ovr;
      rdata[B_MAF]       = mask_q.afull;
      rdata[B_MLOCK]     = mask_q.lock;
      rdata[B_OVR]       = ovr;
      rdata[THR_W-1:0]   = thr_q;
    end
  end

  logic unused_wbits;
  assign unused_wbits = ^{wdata[31:18], wdata[10:9], wdata[7]};
endmodule

// File: rtl/tsb_packer.sv
module tsb_packer import tsb_pkg::*; (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        s_valid,
  input  logic        s_sop,
  input  logic [7:0]  s_data,
  input  logic        flush,
  input  logic        full,
  output logic        word_fire,
  output logic [31:0] word,
  output logic        pkt_fire,
  output logic        ovr_evt
);
  logic             in_pkt_q, in_pkt_n;
  logic             drop_q, drop_n;
  logic [IDX_W-1:0] idx_q, idx_n;
  logic [23:0]      sreg_q;
  logic             take, dropping;
  logic [IDX_W-1:0] pos;

  assign take     = s_valid & (s_sop | in_pkt_q) & ~flush;
  assign pos      = s_sop ? '0 : idx_q;
  assign dropping = s_sop ? full : drop_q;

  assign ovr_evt   = take & s_sop & full;
  assign word_fire = take & ~dropping & (pos[1:0] == 2'd3);
  assign pkt_fire  = take & ~dropping & (pos == IDX_W'(LAST_BYTE));
  assign word      = {s_data, sreg_q};

  always_comb begin
    in_pkt_n = in_pkt_q;
    drop_n   = drop_q;
    idx_n    = idx_q;
    if (flush) begin
      in_pkt_n = 1'b0;
      drop_n   = 1'b0;
      idx_n    = '0;
    end else if (take) begin
      in_pkt_n = (pos != IDX_W'(LAST_BYTE));
      drop_n   = dropping;
      idx_n    = pos + IDX_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      in_pkt_q <= 1'b0;
      drop_q   <= 1'b0;
      idx_q    <= '0;
    end else if (flush | take) begin
      in_pkt_q <= in_pkt_n;
      drop_q   <= drop_n;
      idx_q    <= idx_n;
    end
  end

  for (genvar ln = 0; ln < WORD_BYTES - 1; ln++) begin : g_lane
    logic lane_en;
    assign lane_en = take & (pos[1:0] == 2'(ln));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       sreg_q[ln*8 +: 8] <= '0;
      else if (lane_en) sreg_q[ln*8 +: 8] <= s_data;
    end
  end
endmodule

// File: rtl/tsb_fill.sv
module tsb_fill import tsb_pkg::*; #(
  parameter int BUF_PKTS = 8,
  parameter int ADDR_W   = 32,
  parameter int CNT_W    = 4,
  parameter int PTR_W    = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              kill,
  input  logic              rearm,
  input  logic              ack,
  input  logic [ADDR_W-1:0] base,
  input  logic [THR_W-1:0]  thr,
  input  logic              word_fire,
  input  logic [31:0]       word,
  input  logic              pkt_fire,
  input  logic              ovr_evt,
  output logic [CNT_W-1:0]  cnt,
  output logic              done,
  output logic              ovr,
  output logic              full,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [31:0]       mem_wdata
);
  logic [CNT_W-1:0]  cnt_q, cnt_n;
  logic [PTR_W-1:0]  ptr_q, ptr_n;
  logic              done_q, done_n, ovr_q, ovr_n;
  logic              we_q;
  logic [ADDR_W-1:0] addr_q, addr_n;
  logic [31:0]       data_q;
  logic [7:0]        cnt_inc;
  logic              thr_hit;

  assign full    = (cnt_q == CNT_W'(BUF_PKTS));
  assign cnt_inc = 8'(cnt_q) + 8'd1;
  assign thr_hit = cnt_inc >= 8'(thr);
  assign addr_n  = base + ADDR_W'({ptr_q, 2'b00});

  always_comb begin
    cnt_n  = cnt_q;
    ptr_n  = ptr_q;
    done_n = done_q;
    ovr_n  = ovr_q;
    if (kill | rearm) begin
      cnt_n = '0;
      ptr_n = '0;
    end else begin
      if (pkt_fire && !full) cnt_n = cnt_q + CNT_W'(1);
      if (word_fire)         ptr_n = ptr_q + PTR_W'(1);
    end
    if (kill) begin
      done_n = 1'b0;
      ovr_n  = 1'b0;
    end else begin
      if (pkt_fire && thr_hit) done_n = 1'b1;
      else if (ack)            done_n = 1'b0;
      if (ovr_evt)             ovr_n  = 1'b1;
      else if (ack)            ovr_n  = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      ptr_q  <= '0;
      done_q <= 1'b0;
      ovr_q  <= 1'b0;
      we_q   <= 1'b0;
    end else begin
      cnt_q  <= cnt_n;
      ptr_q  <= ptr_n;
      done_q <= done_n;
      ovr_q  <= ovr_n;
      we_q   <= word_fire;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
      data_q <= '0;
    end else if (word_fire) begin
      addr_q <= addr_n;
      data_q <= word;
    end
  end

  assign cnt       = cnt_q;
  assign done      = done_q;
  assign ovr       = ovr_q;
  assign mem_we    = we_q;
  assign mem_addr  = addr_q;
  assign mem_wdata = data_q;
endmodule

// File: rtl/tsb_top.sv
module tsb_top import tsb_pkg::*; #(
  parameter int BUF_PKTS  = 8,
  parameter int ADDR_W    = 32,
  parameter int THR_RESET = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              s_valid,
  input  logic              s_sop,
  input  logic [7:0]        s_data,
  input  logic              csr_wr,
  input  logic              csr_sel,
  input  logic [31:0]       csr_wdata,
  output logic [31:0]       csr_rdata,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [31:0]       mem_wdata,
  output logic              irq
);
  localparam int CNT_W = $clog2(BUF_PKTS + 1);
  localparam int PTR_W = $clog2(BUF_PKTS * WORDS_PER_PKT + 1);

  logic              rst_n_s;
  logic [ADDR_W-1:0] base_w;
  logic [THR_W-1:0]  thr_w;
  mask_t             mask_w;
  logic              rearm_w, ack_w, kill_w;
  logic [CNT_W-1:0]  cnt_w;
  logic              done_w, ovr_w, full_w;
  logic              word_fire_w, pkt_fire_w, ovr_evt_w;
  logic [31:0]       word_w;

  tsb_rst_sync u_rst (
    .clk(clk), .rst_n(rst_n), .rst_n_sync(rst_n_s)
  );

  tsb_csr #(.ADDR_W(ADDR_W), .CNT_W(CNT_W), .THR_RESET(THR_RESET)) u_csr (
    .clk(clk), .rst_n(rst_n_s), .wr(csr_wr), .sel(csr_sel), .wdata(csr_wdata),
    .cnt(cnt_w), .done(done_w), .ovr(ovr_w), .rdata(csr_rdata),
    .base(base_w), .thr(thr_w), .mask(mask_w),
    .rearm(rearm_w), .ack(ack_w), .kill(kill_w)
  );

  tsb_packer u_pack (
    .clk(clk), .rst_n(rst_n_s), .s_valid(s_valid), .s_sop(s_sop), .s_data(s_data),
    .flush(kill_w | rearm_w), .full(full_w),
    .word_fire(word_fire_w), .word(word_w), .pkt_fire(pkt_fire_w), .ovr_evt(ovr_evt_w)
  );

  tsb_fill #(.BUF_PKTS(BUF_PKTS), .ADDR_W(ADDR_W), .CNT_W(CNT_W), .PTR_W(PTR_W)) u_fill (
    .clk(clk), .rst_n(rst_n_s), .kill(kill_w), .rearm(rearm_w), .ack(ack_w),
    .base(base_w), .thr(thr_w), .word_fire(word_fire_w), .word(word_w),
    .pkt_fire(pkt_fire_w), .ovr_evt(ovr_evt_w),
    .cnt(cnt_w), .done(done_w), .ovr(ovr_w), .full(full_w),
    .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata)
  );

  assign irq = (done_w & ~mask_w.done) | (ovr_w & ~mask_w.ovr);

  logic unused_masks;
  assign unused_masks = mask_w.afull ^ mask_w.lock;
endmodule

// File: rtl/tsb_chk.sv
module tsb_chk #(
  parameter int BUF_PKTS = 8,
  parameter int CNT_W    = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic [CNT_W-1:0] cnt,
  input logic             done,
  input logic             ovr,
  input logic             irq,
  input logic             mem_we,
  input logic             pkt_fire,
  input logic             ovr_evt,
  input logic             ack,
  input logic             rearm,
  input logic             kill
);
  // R3
  cnt_sat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CNT_W'(BUF_PKTS));

  // R5
  full_nowrite_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(cnt == CNT_W'(BUF_PKTS)) |-> !mem_we);

  // R4
  done_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> $past(pkt_fire));

  // R6
  irq_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (done || ovr));

  // R7
  ack_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(ack && !pkt_fire && !ovr_evt) |-> (!done && !ovr));

  // R8
  rearm_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rearm) |-> (cnt == '0));

  // R9
  hold_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(kill) |-> (cnt == '0 && !done && !ovr && !mem_we));
endmodule

bind tsb_top tsb_chk #(.BUF_PKTS(BUF_PKTS), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cnt(cnt_w), .done(done_w), .ovr(ovr_w), .irq(irq),
  .mem_we(mem_we), .pkt_fire(pkt_fire_w), .ovr_evt(ovr_evt_w), .ack(ack_w),
  .rearm(rearm_w), .kill(kill_w)
);

// File: tb/sim_tsb_top.sv
module sim_tsb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NBUF = 8;

  logic        clk, rst_n;
  logic        s_valid, s_sop;
  logic [7:0]  s_data;
  logic        csr_wr, csr_sel;
  logic [31:0] csr_wdata, csr_rdata;
  logic        mem_we;
  logic [31:0] mem_addr, mem_wdata;
  logic        irq;

  int n_chk = 0, n_fail = 0;
  bit finished = 0;

  logic [31:0] q_addr [0:511];
  logic [31:0] q_data [0:511];
  int qh = 0, qt = 0;
  int exp_cnt = 0, exp_ptr = 0;
  logic [31:0] exp_base = 0;

  tsb_top u0 (.*);

  initial clk = 0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(bit ok, string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] mk_ctrl(int cnt, bit md, bit dn, bit run, bit mo,
                                          bit maf, bit ml, bit ov, int thr);
    logic [31:0] v = '0;
    v[31:24] = 8'(cnt);
    v[17] = md; v[16] = dn; v[15] = run; v[14] = mo;
    v[13] = maf; v[12] = ml; v[11] = ov; v[6:0] = 7'(thr);
    return v;
  endfunction

  // memory write monitor: R1, R2
  always @(negedge clk) begin
    if (rst_n && mem_we) begin
      if (qh == qt) begin
        check(0, "R5/R9/R10 unexpected write", mem_addr, 32'h0);
      end else begin
        check(mem_addr == q_addr[qh], "R2 address", mem_addr, q_addr[qh]);
        check(mem_wdata == q_data[qh], "R1 data", mem_wdata, q_data[qh]);
        qh++;
      end
    end
  end

  task automatic csr_write(bit sel, logic [31:0] d);
    @(negedge clk);
    csr_wr = 1; csr_sel = sel; csr_wdata = d;
    @(negedge clk);
    csr_wr = 0;
  endtask

  task automatic csr_read(bit sel, output logic [31:0] d);
    csr_sel = sel;
    #1 d = csr_rdata;
  endtask

  task automatic send_pkt(bit held);
    logic [31:0] w = 0;
    bit push = !held && (exp_cnt < NBUF);
    for (int i = 0; i < 188; i++) begin
      @(negedge clk);
      while ($urandom % 4 == 0) begin s_valid = 0; @(negedge clk); end
      s_valid = 1; s_sop = (i == 0); s_data = 8'($urandom);
      w[(i%4)*8 +: 8] = s_data;
      if (push && i % 4 == 3) begin
        q_addr[qt] = exp_base + 32'(exp_ptr * 4);
        q_data[qt] = w;
        qt++; exp_ptr++;
      end
    end
    @(negedge clk);
    s_valid = 0; s_sop = 0;
    if (push) exp_cnt++;
  endtask

  task automatic check_ctrl(logic [31:0] e, bit eirq, string req);
    logic [31:0] r;
    csr_read(1, r);
    check(r == e, req, r, e);
    check(irq == eirq, {req, " irq"}, 32'(irq), 32'(eirq));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_fail++; n_chk++;
      $display("FAIL watchdog actual=%08h expected=%08h", 0, 1);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    logic [31:0] r;
    void'($urandom(32'd1234));
    rst_n = 0; s_valid = 0; s_sop = 0; s_data = 0;
    csr_wr = 0; csr_sel = 0; csr_wdata = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (3) @(negedge clk);

    // R11 reset state
    check_ctrl(32'h0002_7004, 0, "R11 ctrl");
    csr_read(0, r); check(r == 0, "R11 base", r, 0);
    check(mem_we == 0, "R11 mem_we", 32'(mem_we), 0);

    exp_base = 32'h1000_0000;
    csr_write(0, exp_base);
    csr_read(0, r); check(r == exp_base, "R2 base readback", r, exp_base);
    csr_write(1, mk_ctrl(0, 0, 0, 1, 0, 1, 1, 0, 4));

    // R10 stray bytes outside a packet
    for (int i = 0; i < 6; i++) begin
      @(negedge clk); s_valid = 1; s_sop = 0; s_data = 8'($urandom);
    end
    @(negedge clk); s_valid = 0;
    check_ctrl(mk_ctrl(0, 0, 0, 1, 0, 1, 1, 0, 4), 0, "R10 stray");

    // R3/R4 below threshold
    for (int p = 0; p < 3; p++) send_pkt(0);
    check_ctrl(mk_ctrl(3, 0, 0, 1, 0, 1, 1, 0, 4), 0, "R3 count 3");
    send_pkt(0);
    check_ctrl(mk_ctrl(4, 0, 1, 1, 0, 1, 1, 0, 4), 1, "R4 done at thr");

    // R7 acknowledge
    csr_write(1, mk_ctrl(0, 0, 0, 1, 0, 1, 1, 0, 4) | 32'h100);
    check_ctrl(mk_ctrl(4, 0, 0, 1, 0, 1, 1, 0, 4), 0, "R7 ack");

    // R3 fill to full, R5 overflow
    for (int p = 0; p < 4; p++) send_pkt(0);
    check_ctrl(mk_ctrl(8, 0, 1, 1, 0, 1, 1, 0, 4), 1, "R3 count 8");
    csr_write(1, mk_ctrl(0, 0, 0, 1, 0, 1, 1, 0, 4) | 32'h100);
    send_pkt(0);
    check_ctrl(mk_ctrl(8, 0, 0, 1, 0, 1, 1, 1, 4), 1, "R5 overflow");

    // R6 masks
    csr_write(1, mk_ctrl(0, 1, 0, 1, 1, 1, 1, 0, 4));
    check_ctrl(mk_ctrl(8, 1, 0, 1, 1, 1, 1, 1, 4), 0, "R6 masked");
    csr_write(1, mk_ctrl(0, 1, 0, 1, 1, 0, 0, 0, 4));
    check_ctrl(mk_ctrl(8, 1, 0, 1, 1, 0, 0, 1, 4), 0, "R6 other masks");
    csr_write(1, mk_ctrl(0, 1, 0, 1, 0, 0, 0, 0, 4));
    check_ctrl(mk_ctrl(8, 1, 0, 1, 0, 0, 0, 1, 4), 1, "R6 unmask ovr");

    // R8 re-arm
    exp_base = 32'h2000_0100; exp_cnt = 0; exp_ptr = 0;
    csr_write(0, exp_base);
    check_ctrl(mk_ctrl(0, 1, 0, 1, 0, 0, 0, 1, 4), 1, "R8 rearm");
    send_pkt(0);
    check_ctrl(mk_ctrl(1, 1, 0, 1, 0, 0, 0, 1, 4), 1, "R8 refill");

    // R9 soft reset
    csr_write(1, mk_ctrl(0, 1, 0, 0, 0, 0, 0, 0, 4));
    check_ctrl(mk_ctrl(0, 1, 0, 0, 0, 0, 0, 0, 4), 0, "R9 hold");
    send_pkt(1);
    check_ctrl(mk_ctrl(0, 1, 0, 0, 0, 0, 0, 0, 4), 0, "R9 ignored");
    exp_cnt = 0; exp_ptr = 0;
    csr_write(1, mk_ctrl(0, 0, 0, 1, 0, 0, 0, 0, 1));
    send_pkt(0);
    check_ctrl(mk_ctrl(1, 0, 1, 1, 0, 0, 0, 0, 1), 1, "R9 restart R4 thr1");

    repeat (3) @(negedge clk);
    check(qh == qt, "R1 all words written", 32'(qh), 32'(qt));
    finished = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule